// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Watermark Flag

This block is a first-in first-out buffer of 1024 words of 9 bits that connects two unrelated clock domains. A producer writes on the rising edge of `wclk` and a consumer reads on the rising edge of `rclk`. Both pointers cross between the domains as Gray codes through two-flop synchronizers. The full flag is computed on the write side and the empty flag on the read side.

Besides the active-low empty and full flags, the block drives two fill-level flags from the write side. `half_full` is high when the buffer holds at least half its capacity. `almost_fe` is a single watermark flag that is high near either end of the buffer. The watermark distance X is loaded from the low 9 bits of the write data bus on a falling edge of `def_n`, and it only becomes active when reset is released. If `def_n` is high through reset, X falls back to 256. If `def_n` stays low, the last loaded value is kept across later resets.

Top module: `twin_clk_fifo`

## Requirements
- R1: Words leave on `rdata` in the order in which they were accepted, with no loss and no duplication, including when writes and reads overlap.
- R2: While `rst_n` is low, and on release, the buffer is empty: `empty_n` is 0 and `full_n` is 1. `empty_n` is 0 exactly when the buffer holds no word, and a new low level on it only follows a read.
- R3: `full_n` is 0 exactly when 1024 words are held, and a new low level on it only follows a write.
- R4: A write attempted while `full_n` is 0 stores nothing. The words read out afterwards are exactly the 1024 stored before.
- R5: A read attempted while `empty_n` is 0 removes nothing, and `rdata` keeps the last word read out.
- R6: `half_full` is 1 when 512 or more words are held and 0 when 511 or fewer are held.
- R7: `almost_fe` is 1 when the held count is at most X or at least 1024−X, and 0 strictly between those bounds.
- R8: A 1-to-0 edge of `def_n` captures `wdata[8:0]` as a new X (0 to 511). The captured X becomes active when reset is released while `def_n` is low.
- R9: When `def_n` is 1 through reset, the active X is 256.
- R10: Capturing a new X outside reset leaves the active X unchanged. Holding `def_n` low through a later reset activates the most recently captured X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| wr_en | input | 1 | Write request, taken when `full_n` is 1 |
| wdata | input | 9 | Write data; also the source of X on a `def_n` fall |
| def_n | input | 1 | Watermark define strobe (write clock domain) |
| rclk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request, taken when `empty_n` is 1 |
| rdata | output | 9 | Registered read data; holds the last word read |
| empty_n | output | 1 | Low when the buffer holds no word (read domain) |
| full_n | output | 1 | Low when the buffer holds 1024 words (write domain) |
| half_full | output | 1 | High at 512 or more words (write domain) |
| almost_fe | output | 1 | High at count ≤ X or count ≥ 1024−X (write domain) |

## Verification
The bench walks the fill level across each threshold: 256/257 and 767/768 for the default X, 511/512 for half-full, and 1023/1024 for full. A design with an off-by-one comparison would toggle a flag one word early or late. It hammers a full buffer with writes and an empty buffer with reads. A design that wraps a pointer there would return an extra or stale word, or would change `rdata`. It also loads a new X outside reset and then resets with the strobe held low and with it high. A design that applies X immediately, forgets it across reset, or ignores the default would show the wrong watermark at a count of 60. X = 0 is exercised to confirm that only the completely empty and completely full states raise the watermark.

// File: rtl/tcf_pkg.sv
// Shared defaults and types for the dual-clock FIFO.
package tcf_pkg;

    // Default geometry: address bits and data bits.
    localparam int unsigned TCF_AW = 10;
    localparam int unsigned TCF_DW = 9;

    // Default watermark distance when no value is programmed.
    localparam int unsigned TCF_OFS_DEFAULT = 256;

    // Bundle of the registered write-side status flags.
    typedef struct packed {
        logic full_n;
        logic half;
        logic afe;
    } tcf_wflag_t;

endpackage

// File: rtl/tcf_sync.sv
// Multi-stage synchronizer for a Gray-coded pointer.
// Assumes: the input changes at most one bit per source clock, so any
// sampled value is either the old or the new pointer.
module tcf_sync #(
    parameter int unsigned W      = 11,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first capture flop of the foreign pointer
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= d;
                end
            end else begin : g_next
                // further resolution stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/tcf_ram.sv
// Simple dual-port storage: one write port and one registered read port
// on separate clocks.
// Assumes: the controllers never write and read the same slot in a way
// that matters (full/empty logic keeps them apart).
module tcf_ram #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // store one word per accepted write
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // present one word per accepted read; otherwise hold the last word
    always_ff @(posedge rclk) begin
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/tcf_offset.sv
// Watermark distance register pair.
// A falling edge of def_n captures din into a held register at any time.
// The active distance only loads while rst_n is low: the held value when
// def_n is low, the default when def_n is high.
// Assumes: def_n is driven from the write clock domain.
module tcf_offset #(
    parameter int unsigned OW   = 9,
    parameter int unsigned ODEF = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          def_n,
    input  logic [OW-1:0] din,
    output logic [OW-1:0] ofs
);

    logic          def_q;
    logic [OW-1:0] held;

    // remember the strobe level of the previous cycle
    always_ff @(posedge clk) begin
        def_q <= def_n;
    end

    // capture the bus on a 1-to-0 strobe edge; survives reset on purpose
    always_ff @(posedge clk) begin
        if (def_q && !def_n) held <= din;
    end

    // choose the active distance only while reset is applied
    always_ff @(posedge clk) begin
        if (!rst_n) ofs <= def_n ? OW'(ODEF) : held;
    end

endmodule

// File: rtl/tcf_wside.sv
// Write-side controller: write pointer, full flag and the fill-level flags.
// The fill level is the next write pointer minus the synchronized read
// pointer, so half_full and almost_fe may trail reads by the
// synchronizer depth.
// Assumes: rgray_s is already synchronized into this clock.
module tcf_wside #(
    parameter int unsigned AW = 10,
    parameter int unsigned OW = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OW-1:0]       ofs,
    input  logic [AW:0]         rgray_s,
    output logic [AW-1:0]       waddr,
    output logic [AW:0]         wgray,
    output logic                wr_ok,
    output tcf_pkg::tcf_wflag_t flags
);

    localparam int unsigned PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_C = PW'(1) << AW;
    localparam logic [PW-1:0] HALF_C  = DEPTH_C >> 1;

    logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_s, fill_nx, hi_mark;
    tcf_pkg::tcf_wflag_t flags_nx;

    // Gray-to-binary conversion of a pointer
    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign wr_ok    = wr_en & flags.full_n;
    assign wbin_nx  = wbin + PW'(wr_ok);
    assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
    assign rbin_s   = g2b(rgray_s);
    assign fill_nx  = wbin_nx - rbin_s;
    assign hi_mark  = DEPTH_C - PW'(ofs);
    assign waddr    = wbin[AW-1:0];

    // next-state flags from the next write pointer
    always_comb begin
        flags_nx.full_n = !(wgray_nx == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        flags_nx.half   = (fill_nx >= HALF_C);
        flags_nx.afe    = (fill_nx <= PW'(ofs)) || (fill_nx >= hi_mark);
    end

    // pointer and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin         <= '0;
            wgray        <= '0;
            flags.full_n <= 1'b1;
            flags.half   <= 1'b0;
            flags.afe    <= 1'b1;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
            flags <= flags_nx;
        end
    end

endmodule

// File: rtl/tcf_rside.sv
// Read-side controller: read pointer and empty flag.
// Assumes: wgray_s is already synchronized into this clock.
module tcf_rside #(
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          rd_ok,
    output logic          empty_n
);

    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] rbin, rbin_nx, rgray_nx;

    assign rd_ok    = rd_en & empty_n;
    assign rbin_nx  = rbin + PW'(rd_ok);
    assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
    assign raddr    = rbin[AW-1:0];

    // pointer and empty flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_n <= 1'b0;
        end else begin
            rbin    <= rbin_nx;
            rgray   <= rgray_nx;
            empty_n <= (rgray_nx != wgray_s);
        end
    end

endmodule

// File: rtl/twin_clk_fifo.sv
// Dual-clock FIFO with empty, full, half-full and one programmable
// watermark flag that is active near both ends of the buffer.
// Assumes: rst_n is held low for several cycles of both clocks.
module twin_clk_fifo #(
    parameter int unsigned AW          = tcf_pkg::TCF_AW,
    parameter int unsigned DW          = tcf_pkg::TCF_DW,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OFS_DEFAULT = tcf_pkg::TCF_OFS_DEFAULT
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          def_n,
    input  logic          rclk,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_full,
    output logic          almost_fe
);

    localparam int unsigned OW = AW - 1;

    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic          wr_ok, rd_ok;
    logic [OW-1:0] ofs;
    tcf_pkg::tcf_wflag_t wflags;

    tcf_offset #(.OW(OW), .ODEF(OFS_DEFAULT)) u_ofs (
        .clk   (wclk),
        .rst_n (rst_n),
        .def_n (def_n),
        .din   (wdata[OW-1:0]),
        .ofs   (ofs)
    );

    tcf_wside #(.AW(AW), .OW(OW)) u_wside (
        .clk     (wclk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .ofs     (ofs),
        .rgray_s (rgray_s),
        .waddr   (waddr),
        .wgray   (wgray),
        .wr_ok   (wr_ok),
        .flags   (wflags)
    );

    tcf_rside #(.AW(AW)) u_rside (
        .clk     (rclk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wgray_s (wgray_s),
        .raddr   (raddr),
        .rgray   (rgray),
        .rd_ok   (rd_ok),
        .empty_n (empty_n)
    );

    tcf_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    tcf_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    tcf_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk  (wclk),
        .we    (wr_ok),
        .waddr (waddr),
        .wdata (wdata),
        .rclk  (rclk),
        .re    (rd_ok),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign full_n    = wflags.full_n;
    assign half_full = wflags.half;
    assign almost_fe = wflags.afe;

endmodule

// File: rtl/tcf_chk.sv
// Property checker for twin_clk_fifo, attached by bind.
module tcf_chk #(
    parameter int unsigned DW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] rdata,
    input logic          empty_n,
    input logic          full_n,
    input logic          half_full,
    input logic          almost_fe
);

    // R3
    full_after_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $fell(full_n) |-> $past(wr_en));

    // R2
    empty_after_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $fell(empty_n) |-> $past(rd_en));

    // R5
    rdata_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !($past(rd_en) && $past(empty_n)) |-> $stable(rdata));

    // R6
    full_is_half_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> half_full);

    // R7
    full_is_afe_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> almost_fe);

endmodule

bind twin_clk_fifo tcf_chk #(.DW(DW)) u_tcf_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .empty_n   (empty_n),
    .full_n    (full_n),
    .half_full (half_full),
    .almost_fe (almost_fe)
);

// File: tb/twin_clk_fifo_bench.sv
module twin_clk_fifo_bench;

    logic       wclk = 1'b0, rclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, def_n = 1'b1;
    logic [8:0] wdata = '0;
    logic [8:0] rdata;
    logic       empty_n, full_n, half_full, almost_fe;

    always #4 wclk = ~wclk;      // 125 MHz
    always #5.5 rclk = ~rclk;    // unrelated read clock

    twin_clk_fifo u_twin_clk_fifo (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .def_n(def_n), .rclk(rclk), .rd_en(rd_en), .rdata(rdata),
        .empty_n(empty_n), .full_n(full_n), .half_full(half_full),
        .almost_fe(almost_fe)
    );

    logic [8:0] sbq[$];
    int   occ = 0, seq = 0, xval = 256, latched = 0;
    int   nchk = 0, nfail = 0, sb_chk = 0, sb_fail = 0;
    logic pend = 1'b0;
    logic [8:0] last_out = '0;

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: note each accepted read, then compare the word (R1)
    always @(posedge rclk) pend <= rd_en && empty_n;
    always @(negedge rclk) begin
        if (pend) begin
            sb_chk++;
            if (sbq.size() == 0) begin
                sb_fail++;
                $display("FAIL R1 actual=%0d expected=none (queue empty)", rdata);
            end else begin
                last_out = sbq.pop_front();
                if (rdata !== last_out) begin
                    sb_fail++;
                    $display("FAIL R1 actual=%0d expected=%0d", rdata, last_out);
                end
            end
        end
    end

    // Driver: write n words, pushing each accepted word into the scoreboard
    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge wclk); #1;
            while (!full_n) begin
                wr_en = 1'b0;
                @(posedge wclk); #1;
            end
            wr_en = 1'b1;
            wdata = 9'((seq * 37 + 5) & 511);
            seq++;
            sbq.push_back(wdata);
            occ++;
        end
        @(posedge wclk); #1;
        wr_en = 1'b0;
    endtask

    task automatic pop_words(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge rclk); #1;
            while (!empty_n) begin
                rd_en = 1'b0;
                @(posedge rclk); #1;
            end
            rd_en = 1'b1;
            occ--;
        end
        @(posedge rclk); #1;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(posedge rclk);
        repeat (8) @(posedge wclk);
        #2;
    endtask

    // Compare all four flags against the occupancy model
    task automatic check_flags(input string req);
        settle();
        check({req, " empty_n"},   empty_n,   (occ != 0));
        check({req, " full_n"},    full_n,    (occ != 1024));
        check({req, " half_full"}, half_full, (occ >= 512));
        check({req, " almost_fe"}, almost_fe, (occ <= xval) || (occ >= 1024 - xval));
    endtask

    task automatic fill_to(input int target, input string req);
        push_words(target - occ);
        check_flags($sformatf("%s count=%0d", req, target));
    endtask

    // mode 0: strobe high (default), 1: program new value, 2: keep strobe low
    task automatic do_reset(input int mode, input int x);
        @(posedge wclk); #1;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        if (mode == 0) def_n = 1'b1;
        if (mode == 1) begin
            def_n = 1'b1;
            repeat (3) @(posedge wclk); #1;
            wdata = 9'(x);
            def_n = 1'b0;
            latched = x;
        end
        repeat (6) @(posedge wclk);
        repeat (6) @(posedge rclk);
        @(posedge wclk); #1;
        rst_n = 1'b1;
        sbq.delete();
        occ = 0;
        xval = (mode == 0) ? 256 : latched;
    endtask

    initial begin
        #1_500_000;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk + sb_chk + 1, nfail + sb_fail + 1);
        $finish;
    end

    initial begin
        // R2 / R9: reset state with strobe high
        do_reset(0, 0);
        check_flags("R2 reset");

        // R1: short burst, then overlapping traffic
        push_words(20);
        pop_words(20);
        check_flags("R1 drained");
        fork
            push_words(300);
            pop_words(300);
        join
        check_flags("R1 overlap");

        // R6 / R7 / R3: walk the thresholds with X = 256
        fill_to(256,  "R7");
        fill_to(257,  "R7");
        fill_to(511,  "R6");
        fill_to(512,  "R6");
        fill_to(767,  "R7");
        fill_to(768,  "R7");
        fill_to(1023, "R3");
        fill_to(1024, "R3");

        // R4: writes while full store nothing
        @(posedge wclk); #1;
        wr_en = 1'b1; wdata = 9'h155;
        repeat (4) @(posedge wclk); #1;
        wr_en = 1'b0;
        check_flags("R4 after rejected writes");
        pop_words(1024);
        check_flags("R4 drained");
        check("R4 leftover words", sbq.size(), 0);

        // R5: reads while empty leave rdata alone
        @(posedge rclk); #1;
        rd_en = 1'b1;
        repeat (5) @(posedge rclk); #1;
        rd_en = 1'b0;
        settle();
        check("R5 rdata holds", rdata, last_out);
        check("R5 still empty", empty_n, 0);

        // R8: program X = 100 under reset
        do_reset(1, 100);
        check_flags("R8 reset");
        fill_to(60, "R8");
        // R10: new capture outside reset has no effect yet
        @(posedge wclk); #1; def_n = 1'b1;
        repeat (2) @(posedge wclk); #1;
        wdata = 9'd50; def_n = 1'b0; latched = 50;
        repeat (3) @(posedge wclk); #1;
        check_flags("R10 no effect without reset");
        fill_to(100, "R8");
        fill_to(101, "R8");
        fill_to(923, "R8");
        fill_to(924, "R8");
        pop_words(occ);
        check_flags("R8 drained");

        // R10: strobe kept low through reset activates X = 50
        do_reset(2, 0);
        fill_to(50, "R10");
        fill_to(60, "R10");
        pop_words(occ);

        // R9: strobe high through reset restores 256
        do_reset(0, 0);
        fill_to(60, "R9");
        fill_to(257, "R9");
        pop_words(occ);

        // R7 / R8: X = 0 raises the flag only at the two extremes
        do_reset(1, 0);
        check_flags("R7 x0 empty");
        fill_to(1, "R7 x0");
        fill_to(1023, "R7 x0");
        fill_to(1024, "R7 x0");
        pop_words(occ);
        check_flags("R7 x0 drained");

        $display("== %0d vectors applied, %0d miscompares ==", nchk + sb_chk, nfail + sb_fail);
        $finish;
    end

endmodule